// File: doc/BRIEF.md
# Sleep-State Wake Event Controller

This block decides whether a wake request should bring the platform out of its current sleep state. It watches a set of wake sources: sixteen general-purpose inputs and seven fixed sources. The fixed sources are the power button, the real-time-clock alarm, message-based PCI Express power-management events, the dedicated PCI Express wake pin, SMBus slave wake messages, SMBus reset-style commands and SMBus host-notify messages. Each source latches a sticky status bit on the rising edge of its request. Software clears those bits with a write-one-to-clear strobe.

Each source belongs to one of four wake classes, fixed at elaboration:

| Class | Sources | Rule |
|---|---|---|
| always-on | power button (16), SMBus slave wake message (20), SMBus reset command (21) | enable bit ignored; eligible in S1 to S5, including S5 after override or thermal trip |
| resume-well | RTC alarm (17), PCIe wake pin (19), host-notify (22), GPI 15:13 and 11:8 | enable bit required; eligible in S1 to S5, except S5 entered by override or thermal trip |
| core-well | GPI 12 and 7:0 | enable bit required; S1 only, and only while the core well reports power |
| message | PCIe PME message (18) | enable bit required; S1 only |

The block combines the latched status, the enables and the eligibility of each source into one "pending" flag. A four-state machine turns that flag into a single-clock wake pulse:

| State | Meaning | Transitions |
|---|---|---|
| AWAKE | the platform is running | moves to ARMED once the sleep state is S1 to S5 |
| ARMED | asleep and no wake yet | moves to FIRE on pending, or back to AWAKE if the sleep state leaves S1 to S5 |
| FIRE | drives the wake pulse for exactly one clock | always moves to HOLD |
| HOLD | waits for the pending condition to drop | moves to ARMED when pending clears, or to AWAKE when the sleep state leaves S1 to S5 |

Top module: `wake_event_ctrl`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `status_o` is all zero and `wake_o` is low.
- R2: A rising edge on `req_i[k]` sets `status_o[k]` one clock later, whatever the enables and the sleep state are. If the edge and a clear of the same bit fall in one cycle, the bit is set.
- R3: With `clr_i` high, each bit whose `clr_mask_i` bit is 1 is cleared and the other bits are kept. A request held high does not set its bit again after a clear, because only a new rising edge sets it.
- R4: Sources 16, 20 and 21 ignore their `en_i` bits. Each of them wakes the platform from any sleep state 1 to 5, including S5 with cause 2 or 3.
- R5: Sources 17, 19 and 22, and GPI 15:13 and 11:8, wake only when enabled. They wake from sleep states 1 to 5, but not from S5 when the S5 cause is 2 (override) or 3 (thermal trip).
- R6: GPI 12 and 7:0 wake only when enabled, only from sleep state 1, and only while `core_pwr_i` is high.
- R7: Source 18 (PCIe PME message) wakes only when enabled and only from sleep state 1.
- R8: `sleep_i` codes are 0 for S0 and 1 to 5 for S1 to S5; codes 6 and 7 are treated like S0. `s5_cause_i` codes are 0 for software, 1 for power failure, 2 for override and 3 for thermal trip. No wake is produced while `sleep_i` is 0, 6 or 7.
- R9: `wake_o` is high for exactly one clock when the pending condition arises. It does not rise again while any qualifying status bit stays set, and it re-arms once the pending condition clears or the platform returns to S0.
- R10: A status bit latched while in S0 that is enabled and eligible produces a wake pulse once `sleep_i` moves to a sleeping state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 23 | Raw wake requests: GPI 15:0, then the fixed sources 16 to 22 |
| en_i | input | 23 | Per-source wake enables (bits 16, 20 and 21 are ignored) |
| sleep_i | input | 3 | Current sleep state code |
| s5_cause_i | input | 2 | How S5 was entered |
| core_pwr_i | input | 1 | Core power well is powered |
| clr_i | input | 1 | Write-one-to-clear strobe |
| clr_mask_i | input | 23 | Status bits to clear when the strobe is high |
| status_o | output | 23 | Sticky per-source status |
| wake_o | output | 1 | One-clock wake pulse |

## Verification
The assertions assume that every request and control input is synchronous to the clock. The edge-detection property also assumes that requests are low while reset is asserted. The bench meets both assumptions by driving all inputs on the falling edge, holding requests at zero through reset, and changing the configuration only on falling edges. The configuration is the sleep code, the S5 cause and the core-power flag. The sweep clears all status before each new configuration, so every wake pulse it counts comes from the single request it has just raised.

// File: rtl/wake_evt_pkg.sv
package wake_evt_pkg;

    // Wake class of one source: which sleep states it may leave from.
    typedef enum logic [1:0] {
        CLS_ANY,      // S1..S5, also after override or thermal trip
        CLS_RESUME,   // S1..S5, not after override or thermal trip
        CLS_CORE,     // S1 only, core well must be powered
        CLS_S1ONLY    // S1 only
    } wake_cls_e;

    typedef enum logic [1:0] {
        ST_AWAKE,
        ST_ARMED,
        ST_FIRE,
        ST_HOLD
    } wake_st_e;

    // Fixed sources follow the general-purpose inputs.
    localparam int unsigned FIXED_SRCS      = 7;
    localparam int unsigned OFS_PWRBTN      = 0;
    localparam int unsigned OFS_RTC         = 1;
    localparam int unsigned OFS_PME_MSG     = 2;
    localparam int unsigned OFS_PCIE_PIN    = 3;
    localparam int unsigned OFS_SMB_WAKE    = 4;
    localparam int unsigned OFS_SMB_RESET   = 5;
    localparam int unsigned OFS_HOST_NOTIFY = 6;

    localparam logic [2:0] SLP_S0 = 3'd0;
    localparam logic [2:0] SLP_S1 = 3'd1;
    localparam logic [2:0] SLP_S5 = 3'd5;

    // S5 entry cause codes 0 (software) and 1 (power failure) leave every source open.
    localparam logic [1:0] S5_OVERRIDE = 2'd2;
    localparam logic [1:0] S5_THERMAL  = 2'd3;

    function automatic wake_cls_e fixed_class(input int unsigned ofs);
        wake_cls_e cls;
        case (ofs)
            OFS_PWRBTN, OFS_SMB_WAKE, OFS_SMB_RESET: cls = CLS_ANY;
            OFS_PME_MSG:                             cls = CLS_S1ONLY;
            OFS_RTC, OFS_PCIE_PIN, OFS_HOST_NOTIFY:  cls = CLS_RESUME;
            default:                                 cls = CLS_RESUME;
        endcase
        return cls;
    endfunction

endpackage

// File: rtl/wake_status_bank.sv
module wake_status_bank #(
    parameter int unsigned N_SRC = 23
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [N_SRC-1:0] req_i,
    input  logic             clr_i,
    input  logic [N_SRC-1:0] clr_mask_i,
    output logic [N_SRC-1:0] status_o
);

    logic [N_SRC-1:0] req_q;
    logic [N_SRC-1:0] rise_w;
    logic [N_SRC-1:0] stat_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            req_q <= '0;
        end else begin
            req_q <= req_i;
        end
    end

    assign rise_w = req_i & ~req_q;

    // One sticky bit per source; a new edge wins over a clear in the same cycle.
    for (genvar g = 0; g < N_SRC; g++) begin : g_bit
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                stat_q[g] <= 1'b0;
            end else if (rise_w[g]) begin
                stat_q[g] <= 1'b1;
            end else if (clr_i && clr_mask_i[g]) begin
                stat_q[g] <= 1'b0;
            end
        end
    end

    assign status_o = stat_q;

endmodule

// File: rtl/wake_qualifier.sv
module wake_qualifier
    import wake_evt_pkg::*;
#(
    parameter int unsigned         N_GPI         = 16,
    parameter logic [N_GPI-1:0]    CORE_GPI_MASK = 16'h10FF,
    parameter int unsigned         N_SRC         = N_GPI + FIXED_SRCS
) (
    input  logic [2:0]       sleep_i,
    input  logic [1:0]       s5_cause_i,
    input  logic             core_pwr_i,
    input  logic [N_SRC-1:0] en_i,
    input  logic [N_SRC-1:0] status_i,
    output logic             asleep_o,
    output logic             pending_o
);

    logic             asleep_w;
    logic             in_s1_w;
    logic             restricted_w;
    logic [N_SRC-1:0] elig_w;
    logic [N_SRC-1:0] eff_en_w;

    // Codes 6 and 7 are not sleep states and count as awake.
    assign asleep_w     = (sleep_i >= SLP_S1) && (sleep_i <= SLP_S5);
    assign in_s1_w      = (sleep_i == SLP_S1);
    assign restricted_w = (sleep_i == SLP_S5) &&
                          ((s5_cause_i == S5_OVERRIDE) || (s5_cause_i == S5_THERMAL));

    function automatic logic class_ok(input wake_cls_e cls, input logic asleep,
                                      input logic in_s1, input logic restricted,
                                      input logic core_pwr);
        logic ok;
        unique case (cls)
            CLS_ANY:    ok = asleep;
            CLS_RESUME: ok = asleep && !restricted;
            CLS_CORE:   ok = in_s1 && core_pwr;
            CLS_S1ONLY: ok = in_s1;
            default:    ok = 1'b0;
        endcase
        return ok;
    endfunction

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        if (g < N_GPI) begin : g_gpi
            localparam wake_cls_e CLS = CORE_GPI_MASK[g] ? CLS_CORE : CLS_RESUME;
            assign elig_w[g]   = class_ok(CLS, asleep_w, in_s1_w, restricted_w, core_pwr_i);
            assign eff_en_w[g] = en_i[g];
        end else begin : g_fixed
            localparam wake_cls_e CLS = fixed_class(g - N_GPI);
            assign elig_w[g]   = class_ok(CLS, asleep_w, in_s1_w, restricted_w, core_pwr_i);
            // Always-on sources ignore their enable bit.
            assign eff_en_w[g] = (CLS == CLS_ANY) ? 1'b1 : en_i[g];
        end
    end

    assign asleep_o  = asleep_w;
    assign pending_o = |(status_i & eff_en_w & elig_w);

endmodule

// File: rtl/wake_pulse_fsm.sv
module wake_pulse_fsm
    import wake_evt_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic asleep_i,
    input  logic pending_i,
    output logic wake_o
);

    wake_st_e st_q;
    wake_st_e st_d;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_AWAKE: begin
                if (asleep_i) st_d = ST_ARMED;
            end
            ST_ARMED: begin
                if (!asleep_i)      st_d = ST_AWAKE;
                else if (pending_i) st_d = ST_FIRE;
            end
            ST_FIRE: begin
                st_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (!asleep_i)       st_d = ST_AWAKE;
                else if (!pending_i) st_d = ST_ARMED;
            end
            default: st_d = ST_AWAKE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_AWAKE;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        unique case (st_q)
            ST_FIRE: wake_o = 1'b1;
            default: wake_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/wake_event_ctrl.sv
module wake_event_ctrl
    import wake_evt_pkg::*;
#(
    parameter int unsigned      N_GPI         = 16,
    parameter logic [N_GPI-1:0] CORE_GPI_MASK = 16'h10FF
) (
    input  logic                        clk_i,
    input  logic                        rst_ni,
    input  logic [N_GPI+FIXED_SRCS-1:0] req_i,
    input  logic [N_GPI+FIXED_SRCS-1:0] en_i,
    input  logic [2:0]                  sleep_i,
    input  logic [1:0]                  s5_cause_i,
    input  logic                        core_pwr_i,
    input  logic                        clr_i,
    input  logic [N_GPI+FIXED_SRCS-1:0] clr_mask_i,
    output logic [N_GPI+FIXED_SRCS-1:0] status_o,
    output logic                        wake_o
);

    localparam int unsigned N_SRC = N_GPI + FIXED_SRCS;

    logic [N_SRC-1:0] status_w;
    logic             asleep;
    logic             pending;

    wake_status_bank #(.N_SRC(N_SRC)) u_bank (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .req_i      (req_i),
        .clr_i      (clr_i),
        .clr_mask_i (clr_mask_i),
        .status_o   (status_w)
    );

    wake_qualifier #(
        .N_GPI         (N_GPI),
        .CORE_GPI_MASK (CORE_GPI_MASK),
        .N_SRC         (N_SRC)
    ) u_qual (
        .sleep_i    (sleep_i),
        .s5_cause_i (s5_cause_i),
        .core_pwr_i (core_pwr_i),
        .en_i       (en_i),
        .status_i   (status_w),
        .asleep_o   (asleep),
        .pending_o  (pending)
    );

    wake_pulse_fsm u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .asleep_i  (asleep),
        .pending_i (pending),
        .wake_o    (wake_o)
    );

    assign status_o = status_w;

endmodule

// File: rtl/wake_event_checker.sv
module wake_event_checker #(
    parameter int unsigned N_SRC = 23
) (
    input logic             clk_i,
    input logic             rst_ni,
    input logic [N_SRC-1:0] req_i,
    input logic             clr_i,
    input logic [N_SRC-1:0] clr_mask_i,
    input logic [N_SRC-1:0] status_i,
    input logic [2:0]       sleep_i,
    input logic             pending_i,
    input logic             wake_i
);

    logic [N_SRC-1:0] keep_w;
    assign keep_w = status_i & ~(clr_i ? clr_mask_i : '0);

    // R2: a request edge seen on the ports shows up in the status bits.
    p_latch_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_i & ($past(req_i) & ~$past(req_i, 2))) ==
                  ($past(req_i) & ~$past(req_i, 2))))
        else $error("p_latch_rise_r2");

    // R3: bits that were set and not cleared stay set.
    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((status_i & $past(keep_w)) == $past(keep_w)))
        else $error("p_sticky_r3");

    // R9: the wake pulse lasts exactly one clock.
    p_one_clock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |=> !wake_i)
        else $error("p_one_clock_r9");

    // R9: a pulse follows a cycle with a pending qualified status.
    p_needs_pending_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |-> $past(pending_i))
        else $error("p_needs_pending_r9");

    // R8: no pulse unless the sleep code was 1..5.
    p_no_wake_awake_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_i |-> (($past(sleep_i) >= 3'd1) && ($past(sleep_i) <= 3'd5)))
        else $error("p_no_wake_awake_r8");

endmodule

bind wake_event_ctrl wake_event_checker #(.N_SRC(N_SRC)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_i      (req_i),
    .clr_i      (clr_i),
    .clr_mask_i (clr_mask_i),
    .status_i   (status_o),
    .sleep_i    (sleep_i),
    .pending_i  (pending),
    .wake_i     (wake_o)
);

// File: tb/test_wake_event_ctrl.sv
`timescale 1ns/1ps
module test_wake_event_ctrl;

    localparam int N_SRC = 23;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [N_SRC-1:0] req = '0;
    logic [N_SRC-1:0] en = '0;
    logic [N_SRC-1:0] clr_mask = '0;
    logic [2:0]       slp = 3'd0;
    logic [1:0]       cause = 2'd0;
    logic             core = 1'b0;
    logic             clr = 1'b0;
    logic [N_SRC-1:0] status;
    logic             wake;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    wake_event_ctrl i_wake_event_ctrl (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .req_i      (req),
        .en_i       (en),
        .sleep_i    (slp),
        .s5_cause_i (cause),
        .core_pwr_i (core),
        .clr_i      (clr),
        .clr_mask_i (clr_mask),
        .status_o   (status),
        .wake_o     (wake)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic count_wakes(input int cycles, output int n);
        n = 0;
        for (int k = 0; k < cycles; k++) begin
            @(negedge clk);
            if (wake) n++;
        end
    endtask

    task automatic pulse_req(input int i);
        @(negedge clk) req[i] = 1'b1;
        @(negedge clk) req[i] = 1'b0;
    endtask

    task automatic clear_bits(input logic [N_SRC-1:0] m);
        @(negedge clk) begin clr = 1'b1; clr_mask = m; end
        @(negedge clk) begin clr = 1'b0; clr_mask = '0; end
    endtask

    // Expected wake from the requirement text alone.
    function automatic bit exp_wake(int i, int s, int c, bit cp, bit e);
        bit asleep = (s >= 1) && (s <= 5);
        bit restr  = (s == 5) && (c >= 2);
        if (i == 16 || i == 20 || i == 21) return asleep;
        if (!e) return 1'b0;
        if (i < 16) begin
            if (i == 12 || i < 8) return (s == 1) && cp;
            return asleep && !restr;
        end
        if (i == 18) return s == 1;
        return asleep && !restr;
    endfunction

    function automatic string tag_of(int i, int s);
        if (s == 0 || s > 5) return "R8";
        if (i == 16 || i == 20 || i == 21) return "R4";
        if (i == 18) return "R7";
        if (i < 16 && (i == 12 || i < 8)) return "R6";
        return "R5";
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1 status in reset", status, 0);
        chk("R1 wake in reset", wake, 0);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk("R1 status after reset", status, 0);
        chk("R1 wake after reset", wake, 0);

        // Sweep: every source, state, cause, core flag and enable.
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 4; c++) begin
                for (int cp = 0; cp < 2; cp++) begin
                    for (int i = 0; i < N_SRC; i++) begin
                        for (int e = 0; e < 2; e++) begin
                            @(negedge clk) begin
                                slp = 3'(s); cause = 2'(c); core = cp[0];
                                en = e[0] ? (23'd1 << i) : ~(23'd1 << i);
                            end
                            repeat (2) @(negedge clk);
                            pulse_req(i);
                            count_wakes(6, n);
                            chk($sformatf("%s wake src%0d s%0d c%0d p%0d e%0d", tag_of(i, s), i, s, c, cp, e),
                                n, exp_wake(i, s, c, cp[0], e[0]));
                            chk($sformatf("R2 status src%0d", i), status, 64'(23'd1 << i));
                            clear_bits('1);
                            chk($sformatf("R3 cleared src%0d", i), status, 0);
                        end
                    end
                end
            end
        end

        // R9: single pulse, no refire while pending, re-arm after clear.
        @(negedge clk) begin slp = 3'd1; cause = 2'd0; core = 1'b1; en = '1; end
        repeat (2) @(negedge clk);
        pulse_req(0);
        count_wakes(8, n);
        chk("R9 first pulse", n, 1);
        pulse_req(1);
        count_wakes(8, n);
        chk("R9 no refire while pending", n, 0);
        clear_bits(23'd1);
        count_wakes(4, n);
        chk("R9 still pending after partial clear", n, 0);
        chk("R3 partial clear keeps bit1", status, 2);
        clear_bits(23'd2);
        count_wakes(4, n);
        chk("R9 no pulse once idle", n, 0);
        pulse_req(2);
        count_wakes(8, n);
        chk("R9 re-armed after clear", n, 1);

        // R10 / R9: return to S0 with status held, then sleep again.
        @(negedge clk) slp = 3'd0;
        count_wakes(3, n);
        chk("R8 no pulse in S0", n, 0);
        @(negedge clk) slp = 3'd1;
        count_wakes(8, n);
        chk("R10 pulse after re-entering sleep", n, 1);
        clear_bits('1);

        // R10: latch in S0, then enter S3.
        @(negedge clk) slp = 3'd0;
        pulse_req(16);
        count_wakes(4, n);
        chk("R10 no pulse while in S0", n, 0);
        @(negedge clk) slp = 3'd3;
        count_wakes(8, n);
        chk("R10 pulse on entering S3", n, 1);
        clear_bits('1);

        // R2: edge wins over a clear in the same cycle.
        @(negedge clk) slp = 3'd0;
        @(negedge clk) begin req[5] = 1'b1; clr = 1'b1; clr_mask = '1; end
        @(negedge clk) begin req[5] = 1'b0; clr = 1'b0; clr_mask = '0; end
        chk("R2 set wins over clear", status, 64'(23'd1 << 5));
        clear_bits('1);

        // R3: a held request does not re-latch after a clear.
        @(negedge clk) req[6] = 1'b1;
        repeat (2) @(negedge clk);
        chk("R3 held request latched", status, 64'(23'd1 << 6));
        clear_bits('1);
        repeat (3) @(negedge clk);
        chk("R3 held request not re-latched", status, 0);
        @(negedge clk) req[6] = 1'b0;
        pulse_req(6);
        chk("R3 new edge latches again", status, 64'(23'd1 << 6));
        clear_bits('1);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule